// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM out of power-up. It waits in an idle state after reset until `start` is seen high. It then raises the clock-enable pin and steps through a fixed list of one-cycle commands on a single-phase command bus: precharge-all, an extended mode-register load, a mode-register load that resets the DLL, a long settling wait, a second precharge-all, two auto-refresh commands, and a final mode-register load without the DLL reset. It inserts a parameterised number of idle cycles where the memory needs them.

The command bus carries four active-high request bits (chip select, row strobe, column strobe, write enable) plus an address and a bank address, and all of them are registered. A cycle in which all four request bits are low is a NOP. During a NOP the address and bank lines are held at zero. When the last wait ends, `done` rises and stays high. The system then hands the memory over to the normal controller. All wait lengths and mode-register values are parameters, so a bench can shorten the waits.

Top module: `ddr_boot_seq`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low): `cke`, `cs`, `ras`, `cas`, `we` and `done` are 0, and `addr` and `ba` are 0.
- R2: After reset and before `start` is sampled high, every output keeps its reset value.
- R3: In the cycle after the clock edge that samples `start` high, `cke` is 1 with a NOP and zero `addr`/`ba`. From then on, `cke` stays 1 until reset.
- R4: Precharge-all is `cs`,`ras`,`we` = 1, `cas` = 0, `addr` = 0x0400 (only bit 10 set), `ba` = 0. The first one follows the `cke` cycle directly.
- R5: The extended mode-register load follows the first precharge directly. It is all four request bits = 1, `ba` = 1 and `addr` = 0. It is the only command with a nonzero `ba`.
- R6: The DLL-reset mode-register load follows directly. It is all four bits = 1, `ba` = 0 and `addr` = 0x0132. It is followed by exactly `T_DLL` NOP cycles.
- R7: The second precharge-all (same encoding as in R4) comes right after the `T_DLL` wait.
- R8: Two auto-refresh commands follow. Each is `cs`,`ras`,`cas` = 1, `we` = 0, `addr` = 0, `ba` = 0, and each is followed by exactly `T_REF` NOP cycles.
- R9: The final mode-register load has all four bits = 1, `ba` = 0 and `addr` = 0x0032. It is followed by exactly `T_MR` NOP cycles, and `done` becomes 1 in the next cycle.
- R10: Every command lasts one cycle. In a NOP cycle all four request bits are 0 and `addr`/`ba` are 0.
- R11: Once `done` is 1 it stays 1 with a NOP bus until reset. A `start` seen while busy or done has no effect on the bus sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the sequence when sampled high in idle |
| cke | output | 1 | DRAM clock enable |
| cs | output | 1 | Chip-select request (active high) |
| ras | output | 1 | Row-strobe request (active high) |
| cas | output | 1 | Column-strobe request (active high) |
| we | output | 1 | Write-enable request (active high) |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| done | output | 1 | Initialization finished (sticky) |

## Verification
The outputs are registered copies of the step register, so a wrong step or a wrong counter value appears on the bus in the very next cycle. It shows up as a command in the wrong slot, a wait that is one cycle short or long, or `done` rising early or late. The bench builds the expected bus word for every cycle from the wait lengths alone and compares the whole word each cycle. It does this for a normal configuration and for the minimum one-cycle waits, so an error is reported in the cycle where it first appears.

// File: rtl/ddr_boot_pkg.sv
package ddr_boot_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CKE,
        ST_PRE_A,
        ST_EXT_MR,
        ST_MR_DLL,
        ST_WAIT_DLL,
        ST_PRE_B,
        ST_REF_A,
        ST_WAIT_RA,
        ST_REF_B,
        ST_WAIT_RB,
        ST_MR_RUN,
        ST_WAIT_MR,
        ST_DONE
    } step_e;

    function automatic step_e next_step(step_e s);
        case (s)
            ST_IDLE:     return ST_CKE;
            ST_CKE:      return ST_PRE_A;
            ST_PRE_A:    return ST_EXT_MR;
            ST_EXT_MR:   return ST_MR_DLL;
            ST_MR_DLL:   return ST_WAIT_DLL;
            ST_WAIT_DLL: return ST_PRE_B;
            ST_PRE_B:    return ST_REF_A;
            ST_REF_A:    return ST_WAIT_RA;
            ST_WAIT_RA:  return ST_REF_B;
            ST_REF_B:    return ST_WAIT_RB;
            ST_WAIT_RB:  return ST_MR_RUN;
            ST_MR_RUN:   return ST_WAIT_MR;
            default:     return ST_DONE;
        endcase
    endfunction

    function automatic logic is_wait(step_e s);
        return (s == ST_WAIT_DLL) || (s == ST_WAIT_RA) ||
               (s == ST_WAIT_RB)  || (s == ST_WAIT_MR);
    endfunction

endpackage

// File: rtl/ddr_boot_wait.sv
module ddr_boot_wait
    import ddr_boot_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int T_DLL = 200,
    parameter int T_REF = 4,
    parameter int T_MR  = 200
) (
    input  step_e            step,
    output logic [CNT_W-1:0] len
);

    always_comb begin
        case (step)
            ST_WAIT_DLL:            len = CNT_W'(T_DLL);
            ST_WAIT_RA, ST_WAIT_RB: len = CNT_W'(T_REF);
            ST_WAIT_MR:             len = CNT_W'(T_MR);
            default:                len = '0;
        endcase
    end

endmodule

// File: rtl/ddr_boot_cmd.sv
module ddr_boot_cmd
    import ddr_boot_pkg::*;
#(
    parameter int          ADDR_W     = 13,
    parameter int          BA_W       = 2,
    parameter int          PRE_BIT    = 10,
    parameter logic [15:0] EXT_MR_VAL = 16'h0000,
    parameter logic [15:0] MR_DLL_VAL = 16'h0132,
    parameter logic [15:0] MR_RUN_VAL = 16'h0032
) (
    input  step_e              step,
    output logic               cke,
    output logic               cs,
    output logic               ras,
    output logic               cas,
    output logic               we,
    output logic [ADDR_W-1:0]  addr,
    output logic [BA_W-1:0]    ba,
    output logic               done
);

    localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << PRE_BIT;

    always_comb begin
        cke  = (step != ST_IDLE);
        done = (step == ST_DONE);
        cs   = 1'b0;
        ras  = 1'b0;
        cas  = 1'b0;
        we   = 1'b0;
        addr = '0;
        ba   = '0;
        case (step)
            ST_PRE_A, ST_PRE_B: begin
                {cs, ras, we} = 3'b111;
                addr          = PRE_ADDR;
            end
            ST_EXT_MR: begin
                {cs, ras, cas, we} = 4'b1111;
                addr               = EXT_MR_VAL[ADDR_W-1:0];
                ba                 = BA_W'(1);
            end
            ST_MR_DLL: begin
                {cs, ras, cas, we} = 4'b1111;
                addr               = MR_DLL_VAL[ADDR_W-1:0];
            end
            ST_MR_RUN: begin
                {cs, ras, cas, we} = 4'b1111;
                addr               = MR_RUN_VAL[ADDR_W-1:0];
            end
            ST_REF_A, ST_REF_B: begin
                {cs, ras, cas} = 3'b111;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_boot_seq.sv
module ddr_boot_seq
    import ddr_boot_pkg::*;
#(
    parameter int          ADDR_W     = 13,
    parameter int          BA_W       = 2,
    parameter int          PRE_BIT    = 10,
    parameter logic [15:0] EXT_MR_VAL = 16'h0000,
    parameter logic [15:0] MR_DLL_VAL = 16'h0132,
    parameter logic [15:0] MR_RUN_VAL = 16'h0032,
    parameter int          T_DLL      = 200,
    parameter int          T_REF      = 4,
    parameter int          T_MR       = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              cke,
    output logic              cs,
    output logic              ras,
    output logic              cas,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              done
);

    localparam int T_MAX01 = (T_DLL > T_REF) ? T_DLL : T_REF;
    localparam int T_MAX   = (T_MAX01 > T_MR) ? T_MAX01 : T_MR;
    localparam int CNT_W   = $clog2(T_MAX + 1);

    typedef struct packed {
        step_e            step;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    typedef struct packed {
        logic              cke;
        logic              cs;
        logic              ras;
        logic              cas;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BA_W-1:0]   ba;
        logic              done;
    } bus_t;

    ctl_t             ctl_d, ctl_q;
    bus_t             bus_d, bus_q;
    step_e            step_nx;
    logic [CNT_W-1:0] wait_len;

    assign step_nx = next_step(ctl_q.step);

    ddr_boot_wait #(
        .CNT_W (CNT_W),
        .T_DLL (T_DLL),
        .T_REF (T_REF),
        .T_MR  (T_MR)
    ) u_wait (
        .step (step_nx),
        .len  (wait_len)
    );

    always_comb begin
        logic adv;
        ctl_d = ctl_q;
        adv   = 1'b0;
        if (ctl_q.step == ST_IDLE) begin
            adv = start;
        end else if (ctl_q.step == ST_DONE) begin
            adv = 1'b0;
        end else if (is_wait(ctl_q.step)) begin
            if (ctl_q.cnt <= CNT_W'(1)) adv = 1'b1;
            else                        ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
        end else begin
            adv = 1'b1;
        end
        if (adv) begin
            ctl_d.step = step_nx;
            ctl_d.cnt  = wait_len;
        end
    end

    ddr_boot_cmd #(
        .ADDR_W     (ADDR_W),
        .BA_W       (BA_W),
        .PRE_BIT    (PRE_BIT),
        .EXT_MR_VAL (EXT_MR_VAL),
        .MR_DLL_VAL (MR_DLL_VAL),
        .MR_RUN_VAL (MR_RUN_VAL)
    ) u_cmd (
        .step (ctl_d.step),
        .cke  (bus_d.cke),
        .cs   (bus_d.cs),
        .ras  (bus_d.ras),
        .cas  (bus_d.cas),
        .we   (bus_d.we),
        .addr (bus_d.addr),
        .ba   (bus_d.ba),
        .done (bus_d.done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{step: ST_IDLE, cnt: '0};
            bus_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            bus_q <= bus_d;
        end
    end

    assign cke  = bus_q.cke;
    assign cs   = bus_q.cs;
    assign ras  = bus_q.ras;
    assign cas  = bus_q.cas;
    assign we   = bus_q.we;
    assign addr = bus_q.addr;
    assign ba   = bus_q.ba;
    assign done = bus_q.done;

endmodule

// File: rtl/ddr_boot_chk.sv
module ddr_boot_chk #(
    parameter int          ADDR_W     = 13,
    parameter int          BA_W       = 2,
    parameter int          PRE_BIT    = 10,
    parameter logic [15:0] EXT_MR_VAL = 16'h0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs,
    input logic              ras,
    input logic              cas,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              done
);

    localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << PRE_BIT;

    // R1
    no_cmd_before_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (!cs && !done));

    // R3
    cke_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R4
    pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && ras && !cas && we) |-> (addr == PRE_ADDR && ba == '0));

    // R5
    bank_only_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ba != '0) |-> (cs && ras && cas && we && addr == EXT_MR_VAL[ADDR_W-1:0]));

    // R10
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> (!ras && !cas && !we && addr == '0 && ba == '0));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs |=> !(cs && $stable({ras, cas, we, addr, ba})));

    // R11
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !cs && cke));

endmodule

bind ddr_boot_seq ddr_boot_chk #(
    .ADDR_W     (ADDR_W),
    .BA_W       (BA_W),
    .PRE_BIT    (PRE_BIT),
    .EXT_MR_VAL (EXT_MR_VAL)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .cs    (cs),
    .ras   (ras),
    .cas   (cas),
    .we    (we),
    .addr  (addr),
    .ba    (ba),
    .done  (done)
);

// File: tb/ddr_boot_seq_bench.sv
`timescale 1ns/1ps
module ddr_boot_seq_bench;

    localparam int AW = 13;
    localparam int BW = 2;
    localparam int TD_A = 5, TR_A = 2, TM_A = 6;
    localparam int TD_B = 1, TR_B = 1, TM_B = 1;
    localparam int RUN_LEN = 8 + TD_A + 2*TR_A + TM_A + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    int   checks = 0;
    int   failures = 0;

    always #4 clk = ~clk;

    logic          cke_a, cs_a, ras_a, cas_a, we_a, done_a;
    logic [AW-1:0] addr_a;
    logic [BW-1:0] ba_a;
    logic          cke_b, cs_b, ras_b, cas_b, we_b, done_b;
    logic [AW-1:0] addr_b;
    logic [BW-1:0] ba_b;

    ddr_boot_seq #(.T_DLL(TD_A), .T_REF(TR_A), .T_MR(TM_A)) u_ddr_boot_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cke(cke_a), .cs(cs_a), .ras(ras_a), .cas(cas_a), .we(we_a),
        .addr(addr_a), .ba(ba_a), .done(done_a));

    ddr_boot_seq #(.T_DLL(TD_B), .T_REF(TR_B), .T_MR(TM_B)) u_ddr_boot_seq_min (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cke(cke_b), .cs(cs_b), .ras(ras_b), .cas(cas_b), .we(we_b),
        .addr(addr_b), .ba(ba_b), .done(done_b));

    // word layout: {cke, cs, ras, cas, we, ba, addr, done}
    function automatic logic [20:0] mk(logic k, logic [3:0] c, logic [1:0] b,
                                       logic [12:0] a, logic d);
        return {k, c, b, a, d};
    endfunction

    function automatic logic [20:0] exp_at(int k, int td, int tr, int tm);
        int p2 = 4 + td;
        int r1 = p2 + 1;
        int r2 = r1 + 1 + tr;
        int m  = r2 + 1 + tr;
        int d  = m + 1 + tm;
        if (k == 1 || k == p2) return mk(1, 4'b1101, 0, 13'h0400, 0);
        if (k == 2)            return mk(1, 4'b1111, 1, 13'h0000, 0);
        if (k == 3)            return mk(1, 4'b1111, 0, 13'h0132, 0);
        if (k == r1 || k == r2) return mk(1, 4'b1110, 0, 13'h0000, 0);
        if (k == m)            return mk(1, 4'b1111, 0, 13'h0032, 0);
        if (k >= d)            return mk(1, 4'b0000, 0, 13'h0000, 1);
        return mk(1, 4'b0000, 0, 13'h0000, 0);
    endfunction

    function automatic string tag_at(int k, int td, int tr, int tm);
        int p2 = 4 + td;
        int r1 = p2 + 1;
        int m  = r1 + 2 + 2*tr;
        int d  = m + 1 + tm;
        if (k == 0) return "R3";
        if (k == 1) return "R4";
        if (k == 2) return "R5";
        if (k == 3) return "R6";
        if (k < p2) return "R6/R10";
        if (k == p2) return "R7";
        if (k < m)  return "R8";
        if (k < d)  return "R9";
        return "R11";
    endfunction

    task automatic chk(string tag, logic [20:0] act, logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] word_a();
        return {cke_a, cs_a, ras_a, cas_a, we_a, ba_a, addr_a, done_a};
    endfunction
    function automatic logic [20:0] word_b();
        return {cke_b, cs_b, ras_b, cas_b, we_b, ba_b, addr_b, done_b};
    endfunction

    // mode 0: single pulse, extra pulses mid-run and after done; mode 1: held high
    task automatic run_seq(int mode);
        @(negedge clk);
        start = 1'b1;
        for (int k = 0; k < RUN_LEN; k++) begin
            @(negedge clk);
            if (mode == 1) start = 1'b1;
            else start = (k == 9 || k == RUN_LEN - 3);
            chk(tag_at(k, TD_A, TR_A, TM_A), word_a(), exp_at(k, TD_A, TR_A, TM_A));
            chk(tag_at(k, TD_B, TR_B, TM_B), word_b(), exp_at(k, TD_B, TR_B, TM_B));
        end
        start = 1'b0;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk("R1", word_a(), 21'h0);
        chk("R1", word_b(), 21'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2", word_a(), 21'h0);
            chk("R2", word_b(), 21'h0);
        end
        run_seq(0);
        // R11 still done after extra start pulses
        repeat (4) @(negedge clk);
        chk("R11", word_a(), mk(1, 4'b0000, 0, 13'h0, 1));
        chk("R11", word_b(), mk(1, 4'b0000, 0, 13'h0, 1));
        // reset during a run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        start = 1'b1;
        repeat (6) @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1", word_a(), 21'h0);
        chk("R1", word_b(), 21'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", word_a(), 21'h0);
        run_seq(1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule